// File: doc/BRIEF.md
# Stub Level-2 Cache Controller Register File

This block gives system software the register window of a level-2 cache controller that has no cache behind it. Boot code can still probe the identification word, program the enable bit, set up the auxiliary, latency and address-filter registers, and start maintenance operations. Each maintenance operation reads back as already finished, so software that polls for completion never stalls.

The block sits on a simple synchronous register bus. It decodes only the low 12 bits of the address, so its 4 KiB window repeats through any larger region it is mapped into. A write takes effect on the clock edge where the write strobe is high. Read data is registered and appears in the cycle after the read strobe, and it is zero after any cycle without a read.

The cache-type word is special. Each read of it ORs bits taken from the auxiliary-control register into a stored word, which is not touched by reset. Its value therefore builds up over time. An access to an offset the map does not cover returns zero, changes nothing and raises an error flag for one cycle.

Top module: `l2stub_regs`

## Requirements
- R1: Only address bits [11:0] select a register; for example, offset 0x1108 reads the register at 0x108, and a write to 0xF100 lands in the register at 0x100.
- R2: Every offset from 0x730 up to and including 0x7FF reads as zero with no error, and a write to any of them changes no register.
- R3: Offset 0x000 always reads 0x410000C8, and a write to it is ignored with no error.
- R4: The control register at 0x100 stores only write-data bit 0; read bits [31:1] are always zero.
- R5: Offsets 0x104 (auxiliary control), 0x108 (tag latency) and 0x10C (data latency) each store and return a full 32-bit value.
- R6: Offsets 0xC00 (filter start) and 0xC04 (filter end) each store and return a full 32-bit value.
- R7: While reset is low, and after it is released, read data and the error flag are zero. The auxiliary-control register holds 0x02020000, and the other five writable registers hold zero.
- R8: A read of 0x004 forms f = {aux[19:17], 1'b0, aux[16]}. It ORs f<<18 and f<<6 into the stored type word, returns the updated word, and keeps it.
- R9: The stored type word starts at 0x1C100100. It is left unchanged by reset and by any write, including a write to 0x004, and a read is the only thing that can change it.
- R10: Offsets 0xF40, 0xF60 and 0xF80 read as zero, ignore writes, and raise no error.
- R11: Any other offset reads zero and ignores writes. The error flag is high in the cycle after such an access (read or write) and only then.
- R12: Read data for a read strobe appears in the next cycle and is zero after a cycle with no read. A read and a write in the same cycle to the same register return the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W (32) | Access address; only bits [11:0] are decoded |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_re |
| bus_err | output | 1 | One-cycle flag for an access to an unmapped offset |

## Verification
The assertions hold on every cycle for these rules: the identification readback, zero data from the maintenance window, the masked control readback, and an error flag that is only ever caused by a real access. They also check that the type word only gains bits, and only on a read. The bench scenarios show the rest: the exact bits gathered from the auxiliary register, the type word keeping its value across reset, the reset values, address aliasing, and the old-value result of a read and write in the same cycle.

// File: rtl/l2stub_pkg.sv
package l2stub_pkg;

  localparam int DW   = 32;
  localparam int OFFW = 12;
  localparam int NRW  = 6;   // writable registers held in the bank

  // Bank slot order: control, auxiliary, tag latency, data latency,
  // filter start, filter end.
  typedef enum logic [3:0] {
    SEL_ID, SEL_TYPE, SEL_CTRL, SEL_AUX, SEL_TAG, SEL_DATA,
    SEL_FSTART, SEL_FEND, SEL_QUIET, SEL_BAD
  } sel_e;

  // Offset to register selection (R1, R2, R10, R11).
  function automatic sel_e decode_off(input logic [OFFW-1:0] off);
    if (off >= 12'h730 && off < 12'h800) return SEL_QUIET;
    case (off)
      12'h000: return SEL_ID;
      12'h004: return SEL_TYPE;
      12'h100: return SEL_CTRL;
      12'h104: return SEL_AUX;
      12'h108: return SEL_TAG;
      12'h10C: return SEL_DATA;
      12'hC00: return SEL_FSTART;
      12'hC04: return SEL_FEND;
      12'hF40, 12'hF60, 12'hF80: return SEL_QUIET;
      default: return SEL_BAD;
    endcase
  endfunction

  // Bank slot of a selection; NRW means no writable slot.
  function automatic int unsigned slot_of(input sel_e s);
    case (s)
      SEL_CTRL:   return 0;
      SEL_AUX:    return 1;
      SEL_TAG:    return 2;
      SEL_DATA:   return 3;
      SEL_FSTART: return 4;
      SEL_FEND:   return 5;
      default:    return NRW;
    endcase
  endfunction

  // Bits the auxiliary register adds to the type word (R8).
  function automatic logic [DW-1:0] type_or_mask(input logic [DW-1:0] aux);
    logic [DW-1:0] f;
    f = {{(DW-5){1'b0}}, aux[19:17], 1'b0, aux[16]};
    return (f << 18) | (f << 6);
  endfunction

endpackage

// File: rtl/l2stub_decode.sv
module l2stub_decode
  import l2stub_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel,
  output logic [NRW-1:0]    slot_hit,
  output logic              is_bad
);

  always_comb sel = decode_off(addr[OFFW-1:0]);

  for (genvar i = 0; i < NRW; i++) begin : g_hit
    assign slot_hit[i] = (slot_of(sel) == i);
  end

  assign is_bad = (sel == SEL_BAD);

endmodule

// File: rtl/l2stub_bank.sv
module l2stub_bank #(
  parameter int               DW     = 32,
  parameter int               NREG   = 6,
  parameter logic [NREG*DW-1:0] RST_FLAT = '0,
  parameter logic [NREG*DW-1:0] MASK_FLAT = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NREG-1:0]    wr_en,
  input  logic [DW-1:0]      wdata,
  output logic [NREG*DW-1:0] q_flat
);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DW-1:0] RSTV = RST_FLAT[i*DW +: DW];
    localparam logic [DW-1:0] MSKV = MASK_FLAT[i*DW +: DW];
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)        q <= RSTV;
      else if (wr_en[i]) q <= wdata & MSKV;
    end
    assign q_flat[i*DW +: DW] = q;
  end

endmodule

// File: rtl/l2stub_typeword.sv
module l2stub_typeword #(
  parameter int            DW        = 32,
  parameter logic [DW-1:0] TYPE_INIT = 32'h1C10_0100
) (
  input  logic          clk,
  input  logic          rd_strobe,
  input  logic [DW-1:0] aux,
  output logic [DW-1:0] cur,
  output logic [DW-1:0] q
);

  // Deliberately outside reset: the word keeps what it gathered (R9).
  logic [DW-1:0] q_r = TYPE_INIT;

  always_comb cur = q_r | l2stub_pkg::type_or_mask(aux);

  always_ff @(posedge clk) begin
    if (rd_strobe) q_r <= cur;
  end

  assign q = q_r;

endmodule

// File: rtl/l2stub_regs.sv
module l2stub_regs
  import l2stub_pkg::*;
#(
  parameter int            ADDR_W    = 32,
  parameter logic [DW-1:0] ID_WORD   = 32'h4100_00C8,
  parameter logic [DW-1:0] AUX_RST   = 32'h0202_0000,
  parameter logic [DW-1:0] CTRL_MASK = 32'h0000_0001,
  parameter logic [DW-1:0] TYPE_INIT = 32'h1C10_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_re,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_err
);

  localparam logic [NRW*DW-1:0] RST_FLAT  = {{4{32'h0}}, AUX_RST, 32'h0};
  localparam logic [NRW*DW-1:0] MASK_FLAT = {{5{32'hFFFF_FFFF}}, CTRL_MASK};

  sel_e              sel;
  logic [NRW-1:0]    slot_hit;
  logic              is_bad;
  logic [NRW-1:0]    bank_we;
  logic [NRW*DW-1:0] bank_q;
  logic [DW-1:0]     type_cur;
  logic [DW-1:0]     type_q;
  logic              ev_type_rd;
  logic [DW-1:0]     rd_value;

  l2stub_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr     (bus_addr),
    .sel      (sel),
    .slot_hit (slot_hit),
    .is_bad   (is_bad)
  );

  assign bank_we = slot_hit & {NRW{bus_we}};

  l2stub_bank #(
    .DW(DW), .NREG(NRW), .RST_FLAT(RST_FLAT), .MASK_FLAT(MASK_FLAT)
  ) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (bank_we),
    .wdata  (bus_wdata),
    .q_flat (bank_q)
  );

  assign ev_type_rd = bus_re && (sel == SEL_TYPE);

  l2stub_typeword #(.DW(DW), .TYPE_INIT(TYPE_INIT)) u_type (
    .clk       (clk),
    .rd_strobe (ev_type_rd),
    .aux       (bank_q[1*DW +: DW]),
    .cur       (type_cur),
    .q         (type_q)
  );

  always_comb begin
    case (sel)
      SEL_ID:   rd_value = ID_WORD;
      SEL_TYPE: rd_value = type_cur;
      SEL_CTRL, SEL_AUX, SEL_TAG, SEL_DATA, SEL_FSTART, SEL_FEND:
                rd_value = bank_q[slot_of(sel)*DW +: DW];
      default:  rd_value = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= bus_re ? rd_value : '0;
      bus_err   <= (bus_re || bus_we) && is_bad;
    end
  end

endmodule

// File: rtl/l2stub_regs_chk.sv
module l2stub_regs_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              bus_re,
  input logic [31:0]       bus_rdata,
  input logic              bus_err,
  input logic [31:0]       type_q
);

  logic [11:0] off;
  assign off = bus_addr[11:0];

  p_id_const_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && off == 12'h000) |=> (bus_rdata == 32'h4100_00C8));

  p_quiet_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && off >= 12'h730 && off < 12'h800) |=> (bus_rdata == 32'h0 && !bus_err));

  p_ctrl_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && off == 12'h100) |=> (bus_rdata[31:1] == 31'h0));

  p_err_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_re || bus_we));

  p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> (bus_rdata == 32'h0));

  p_type_grows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(type_q) & ~type_q) == 32'h0));

  p_type_readonly_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(type_q));

endmodule

bind l2stub_regs l2stub_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_rdata (bus_rdata),
  .bus_err   (bus_err),
  .type_q    (type_q)
);

// File: tb/l2stub_regs_tb.sv
`timescale 1ns/1ps
module l2stub_regs_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;

  int applied = 0;
  int miscompares = 0;
  logic [31:0] type_model = 32'h1C10_0100;

  always #2.5 clk = ~clk;

  l2stub_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_re(re), .bus_rdata(rdata), .bus_err(err)
  );

  // {req[3:0], we, re, addr[15:0], wdata[31:0], exp_rdata[31:0], exp_err}
  localparam int NV = 48;
  localparam logic [86:0] VEC [NV] = '{
    {4'd3, 1'b0,1'b1,16'h0000,32'h0,        32'h410000C8,1'b0}, // R3
    {4'd3, 1'b1,1'b0,16'h0000,32'hFFFFFFFF, 32'h0,       1'b0}, // R3
    {4'd3, 1'b0,1'b1,16'h0000,32'h0,        32'h410000C8,1'b0}, // R3
    {4'd7, 1'b0,1'b1,16'h0104,32'h0,        32'h02020000,1'b0}, // R7
    {4'd7, 1'b0,1'b1,16'h0100,32'h0,        32'h0,       1'b0}, // R7
    {4'd7, 1'b0,1'b1,16'h0108,32'h0,        32'h0,       1'b0}, // R7
    {4'd7, 1'b0,1'b1,16'h010C,32'h0,        32'h0,       1'b0}, // R7
    {4'd7, 1'b0,1'b1,16'h0C00,32'h0,        32'h0,       1'b0}, // R7
    {4'd7, 1'b0,1'b1,16'h0C04,32'h0,        32'h0,       1'b0}, // R7
    {4'd4, 1'b1,1'b0,16'h0100,32'hFFFFFFFF, 32'h0,       1'b0}, // R4
    {4'd4, 1'b0,1'b1,16'h0100,32'h0,        32'h1,       1'b0}, // R4
    {4'd4, 1'b1,1'b0,16'h0100,32'hFFFFFFFE, 32'h0,       1'b0}, // R4
    {4'd4, 1'b0,1'b1,16'h0100,32'h0,        32'h0,       1'b0}, // R4
    {4'd5, 1'b1,1'b0,16'h0108,32'hA5A5A5A5, 32'h0,       1'b0}, // R5
    {4'd5, 1'b0,1'b1,16'h0108,32'h0,        32'hA5A5A5A5,1'b0}, // R5
    {4'd5, 1'b1,1'b0,16'h010C,32'h5A5A1234, 32'h0,       1'b0}, // R5
    {4'd5, 1'b0,1'b1,16'h010C,32'h0,        32'h5A5A1234,1'b0}, // R5
    {4'd6, 1'b1,1'b0,16'h0C00,32'h80000000, 32'h0,       1'b0}, // R6
    {4'd6, 1'b1,1'b0,16'h0C04,32'h8FFFFFFF, 32'h0,       1'b0}, // R6
    {4'd6, 1'b0,1'b1,16'h0C00,32'h0,        32'h80000000,1'b0}, // R6
    {4'd6, 1'b0,1'b1,16'h0C04,32'h0,        32'h8FFFFFFF,1'b0}, // R6
    {4'd1, 1'b0,1'b1,16'h1108,32'h0,        32'hA5A5A5A5,1'b0}, // R1
    {4'd1, 1'b1,1'b0,16'hF100,32'h00000003, 32'h0,       1'b0}, // R1
    {4'd1, 1'b0,1'b1,16'h0100,32'h0,        32'h1,       1'b0}, // R1
    {4'd2, 1'b1,1'b0,16'h0730,32'hDEADBEEF, 32'h0,       1'b0}, // R2
    {4'd2, 1'b0,1'b1,16'h0730,32'h0,        32'h0,       1'b0}, // R2
    {4'd2, 1'b0,1'b1,16'h07FC,32'h0,        32'h0,       1'b0}, // R2
    {4'd11,1'b0,1'b1,16'h0800,32'h0,        32'h0,       1'b1}, // R11
    {4'd11,1'b0,1'b1,16'h072C,32'h0,        32'h0,       1'b1}, // R11
    {4'd10,1'b1,1'b0,16'h0F40,32'hFFFFFFFF, 32'h0,       1'b0}, // R10
    {4'd10,1'b0,1'b1,16'h0F60,32'h0,        32'h0,       1'b0}, // R10
    {4'd10,1'b0,1'b1,16'h0F80,32'h0,        32'h0,       1'b0}, // R10
    {4'd11,1'b1,1'b0,16'h0F44,32'h00001234, 32'h0,       1'b1}, // R11
    {4'd11,1'b1,1'b0,16'h0102,32'h00000000, 32'h0,       1'b1}, // R11
    {4'd11,1'b0,1'b1,16'h0100,32'h0,        32'h1,       1'b0}, // R11
    {4'd12,1'b0,1'b0,16'h0100,32'h0,        32'h0,       1'b0}, // R12
    {4'd8, 1'b0,1'b1,16'h0004,32'h0,        32'h1C100100,1'b0}, // R8
    {4'd9, 1'b1,1'b0,16'h0004,32'hFFFFFFFF, 32'h0,       1'b0}, // R9
    {4'd9, 1'b0,1'b1,16'h0004,32'h0,        32'h1C100100,1'b0}, // R9
    {4'd8, 1'b1,1'b0,16'h0104,32'h00010000, 32'h0,       1'b0}, // R8
    {4'd8, 1'b0,1'b1,16'h0004,32'h0,        32'h1C140140,1'b0}, // R8
    {4'd8, 1'b1,1'b0,16'h0104,32'h000F0000, 32'h0,       1'b0}, // R8
    {4'd8, 1'b0,1'b1,16'h0004,32'h0,        32'h1C740740,1'b0}, // R8
    {4'd8, 1'b1,1'b0,16'h0104,32'h00000000, 32'h0,       1'b0}, // R8
    {4'd8, 1'b0,1'b1,16'h0004,32'h0,        32'h1C740740,1'b0}, // R8
    {4'd12,1'b1,1'b1,16'h0108,32'h11112222, 32'hA5A5A5A5,1'b0}, // R12
    {4'd12,1'b0,1'b1,16'h0108,32'h0,        32'h11112222,1'b0}, // R12
    {4'd11,1'b0,1'b0,16'h0000,32'h0,        32'h0,       1'b0}  // R11
  };

  // Bench restatement of the type-word gathering rule (R8).
  function automatic logic [31:0] gather(input logic [31:0] a);
    logic [31:0] m;
    m = '0;
    m[20 +: 3] = a[19:17];
    m[18]      = a[16];
    m[8 +: 3]  = a[19:17];
    m[6]       = a[16];
    return m;
  endfunction

  task automatic check(input int req, input logic [31:0] exp_rd, input logic exp_err);
    applied++;
    if (rdata !== exp_rd || err !== exp_err) begin
      miscompares++;
      $display("FAIL R%0d addr=%h rdata=%h exp=%h err=%b exp=%b",
               req, addr, rdata, exp_rd, err, exp_err);
    end
  endtask

  // Called just after a falling edge; checks at the next falling edge.
  task automatic access(input int req, input logic w, input logic r,
                        input logic [31:0] a, input logic [31:0] d,
                        input logic [31:0] exp_rd, input logic exp_err);
    we = w; re = r; addr = a; wdata = d;
    @(negedge clk);
    check(req, exp_rd, exp_err);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    // R7: outputs held at zero in reset, even with a read pending
    re = 1'b1; addr = 32'h0;
    repeat (3) @(negedge clk);
    check(7, 32'h0, 1'b0);
    re = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check(7, 32'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      access(int'(VEC[i][86:83]), VEC[i][82], VEC[i][81],
             {16'h0, VEC[i][80:65]}, VEC[i][64:33], VEC[i][32:1], VEC[i][0]);
    end
    type_model = 32'h1C740740;

    // R7 / R9: reset mid-run; registers reload, type word survives
    we = 1'b0; re = 1'b1; addr = 32'h0000_0104;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(7, 32'h0, 1'b0);
    re = 1'b0;
    rst_n = 1'b1;
    access(7, 1'b0, 1'b1, 32'h0000_0104, 32'h0, 32'h0202_0000, 1'b0);
    access(7, 1'b0, 1'b1, 32'h0000_0100, 32'h0, 32'h0, 1'b0);
    access(7, 1'b0, 1'b1, 32'h0000_0108, 32'h0, 32'h0, 1'b0);
    access(7, 1'b0, 1'b1, 32'h0000_0C04, 32'h0, 32'h0, 1'b0);
    type_model = type_model | gather(32'h0202_0000);
    access(9, 1'b0, 1'b1, 32'h0000_0004, 32'h0, type_model, 1'b0);

    // R8: gather with all four source bits set, high address alias (R1)
    access(8, 1'b1, 1'b0, 32'hABCD_E104, 32'hFFFF_FFFF, 32'h0, 1'b0);
    type_model = type_model | gather(32'hFFFF_FFFF);
    access(8, 1'b0, 1'b1, 32'h0000_0004, 32'h0, type_model, 1'b0);

    // R11: back-to-back unmapped accesses keep the flag up, then it drops
    access(11, 1'b0, 1'b1, 32'h0000_0FFC, 32'h0, 32'h0, 1'b1);
    access(11, 1'b1, 1'b0, 32'h0000_0110, 32'h1, 32'h0, 1'b1);
    access(11, 1'b0, 1'b1, 32'h0000_0F40, 32'h0, 32'h0, 1'b0);

    we = 1'b0; re = 1'b0;
    @(negedge clk);
    summary();
    $finish;
  end

endmodule